// File: doc/BRIEF.md
# Register-Mapped GPIO Port Controller

This block gives a processor control over a bank of general-purpose pins through a small word-addressed register bus. Each pin's level can be read back through a two-stage synchroniser. Each pin drives from one output latch. Software changes that latch in one of three ways: a full-word load, a write-one-to-set mask, or a write-one-to-clear mask. A single-bit update therefore needs no read-modify-write.

A direction register decides which pins drive. Its polarity is fixed when the block is built: either a 1 marks an output, or a 1 marks an input. A second build option reverses the correspondence between pin numbers and register bits, for software that numbers pins from the most significant end. Writes take effect on the clock edge where the write strobe is high. Reads return data combinationally from the current address.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the output latch is 0 and no pin is driven (`pin_oe` all 0). The direction register reads all 0 with output polarity and all 1 with input polarity.
- R2: A read at word offset 0 returns the pin levels, one bit per pin. A change on `pin_in` becomes visible there after exactly two rising clock edges.
- R3: A write to offset 0 loads the whole output latch with `bus_wdata`. The new value appears on `pin_out` after that edge.
- R4: A write to offset 1 sets to 1 every latch bit whose `bus_wdata` bit is 1. Bits written as 0 keep their value.
- R5: A write to offset 2 clears to 0 every latch bit whose `bus_wdata` bit is 1. Bits written as 0 keep their value. If a set mask and a clear mask ever reach the latch together, clear wins.
- R6: With output polarity (`DIR_ONE_IS_OUT`=1), a write to offset 3 stores the direction word, and a 1 enables the pin's driver.
- R7: With input polarity (`DIR_ONE_IS_OUT`=0), a 1 in the direction word makes the pin an input, so `pin_oe` is the complement of the stored word.
- R8: With `BIT_REVERSE`=1, pin n maps to register bit WIDTH-1-n for the data read, the output latch and the direction word. Otherwise pin n maps to bit n.
- R9: With `SET_READABLE`=1, a read at offset 1 returns the output latch. With `SET_READABLE`=0 it returns 0. A read at offset 2 always returns 0.
- R10: Reads at any offset of 4 or above return 0.
- R11: While `bus_wr` is low, neither the output latch nor the direction register changes, whatever `bus_addr` and `bus_wdata` carry.
- R12: `WIDTH` must be 8, 16, 32 or 64. Any other value stops elaboration. The number of pins equals `WIDTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Word offset of the register |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for `bus_addr` |
| pin_in | input | WIDTH | Pad input levels, asynchronous |
| pin_out | output | WIDTH | Output latch, in pin order |
| pin_oe | output | WIDTH | Driver enable per pin, 1 drives |

## Verification
The assertions rely on these properties of the inputs:
- The bus carries at most one write per cycle, so the decoded write strobes are mutually exclusive.
- The latency check on the synchroniser assumes `pin_in` is sampled on clock edges, as in a synchronous bench.

The stimulus meets both conditions. It changes every input on the falling edge, raises `bus_wr` for exactly one cycle per access, and leaves `bus_wr` low between accesses.

During idle cycles the bench still drives non-zero addresses and data. This tests that those values have no effect while `bus_wr` is low.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int unsigned OFS_LEVEL = 0;
   localparam int unsigned OFS_SET   = 1;
   localparam int unsigned OFS_CLR   = 2;
   localparam int unsigned OFS_DIR   = 3;
   localparam int unsigned NUM_REGS  = 4;
   localparam int unsigned SYNC_STAGES = 2;

   typedef struct packed {
      logic level;
      logic set;
      logic clr;
      logic dir;
   } wr_sel_t;

   function automatic bit width_legal(int unsigned w);
      return (w == 8) || (w == 16) || (w == 32) || (w == 64);
   endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   import gpio_pkg::*;

   logic [WIDTH-1:0] stage [SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= '0;
      end else begin
         stage[0] <= async_in;
         for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
      end
   end

   assign sync_out = stage[SYNC_STAGES-1];

   logic [1:0] run_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               run_cnt <= '0;
      else if (run_cnt != 2'd2) run_cnt <= run_cnt + 2'd1;
   end

   // R2
   sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cnt == 2'd2) |-> (sync_out == $past(async_in, 2)));
endmodule

// File: rtl/gpio_bitmap.sv
module gpio_bitmap #(
   parameter int unsigned WIDTH   = 32,
   parameter bit          REVERSE = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   output logic [WIDTH-1:0] y
);
   generate
      if (REVERSE) begin : g_rev
         for (genvar n = 0; n < WIDTH; n++) begin : g_bit
            assign y[n] = a[WIDTH-1-n];
         end
      end else begin : g_thru
         assign y = a;
      end
   endgenerate
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [WIDTH-1:0] load_val,
   input  logic [WIDTH-1:0] set_mask,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] nxt;

   always_comb begin
      nxt = load_en ? load_val : q;
      nxt = (nxt | set_mask) & ~clr_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   // R4
   latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && (clr_mask == '0)) |=> ((q & $past(set_mask)) == $past(set_mask)));
   // R5
   latch_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask != '0) |=> ((q & $past(clr_mask)) == '0));
   // R11
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && (set_mask == '0) && (clr_mask == '0)) |=> $stable(q));
   // R3
   latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && (set_mask == '0) && (clr_mask == '0)) |=> (q == $past(load_val)));
endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
   parameter int unsigned WIDTH          = 32,
   parameter bit          DIR_ONE_IS_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] drive_en
);
   localparam logic [WIDTH-1:0] RESET_WORD = DIR_ONE_IS_OUT ? '0 : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dir_q <= RESET_WORD;
      else if (wr_en) dir_q <= wdata;
   end

   generate
      if (DIR_ONE_IS_OUT) begin : g_out_pol
         assign drive_en = dir_q;
      end else begin : g_in_pol
         assign drive_en = ~dir_q;
      end
   endgenerate

   // R6
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (dir_q == $past(wdata)));
   // R11
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(dir_q));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
   parameter int unsigned WIDTH          = 32,
   parameter int unsigned ADDR_W         = 3,
   parameter bit          DIR_ONE_IS_OUT = 1'b1,
   parameter bit          BIT_REVERSE    = 1'b0,
   parameter bit          SET_READABLE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe
);
   import gpio_pkg::*;

   // R12
   generate
      if (!width_legal(WIDTH)) begin : g_bad_width
         $error("gpio_port_ctrl: WIDTH must be 8, 16, 32 or 64");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("gpio_port_ctrl: ADDR_W must cover four registers");
      end
   endgenerate

   wr_sel_t wsel;
   always_comb begin
      wsel       = '0;
      wsel.level = bus_wr && (bus_addr == ADDR_W'(OFS_LEVEL));
      wsel.set   = bus_wr && (bus_addr == ADDR_W'(OFS_SET));
      wsel.clr   = bus_wr && (bus_addr == ADDR_W'(OFS_CLR));
      wsel.dir   = bus_wr && (bus_addr == ADDR_W'(OFS_DIR));
   end

   logic [WIDTH-1:0] set_mask, clr_mask;
   assign set_mask = wsel.set ? bus_wdata : '0;
   assign clr_mask = wsel.clr ? bus_wdata : '0;

   logic [WIDTH-1:0] pin_sync, level_reg, latch_reg, dir_word, drive_reg;

   gpio_sync #(.WIDTH(WIDTH)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync));

   gpio_bitmap #(.WIDTH(WIDTH), .REVERSE(BIT_REVERSE)) u_map_in (
      .a(pin_sync), .y(level_reg));

   gpio_out_latch #(.WIDTH(WIDTH)) u_latch (
      .clk(clk), .rst_n(rst_n),
      .load_en(wsel.level), .load_val(bus_wdata),
      .set_mask(set_mask), .clr_mask(clr_mask),
      .q(latch_reg));

   gpio_dir_reg #(.WIDTH(WIDTH), .DIR_ONE_IS_OUT(DIR_ONE_IS_OUT)) u_dir (
      .clk(clk), .rst_n(rst_n), .wr_en(wsel.dir), .wdata(bus_wdata),
      .dir_q(dir_word), .drive_en(drive_reg));

   gpio_bitmap #(.WIDTH(WIDTH), .REVERSE(BIT_REVERSE)) u_map_out (
      .a(latch_reg), .y(pin_out));

   gpio_bitmap #(.WIDTH(WIDTH), .REVERSE(BIT_REVERSE)) u_map_oe (
      .a(drive_reg), .y(pin_oe));

   logic [WIDTH-1:0] set_view;
   generate
      if (SET_READABLE) begin : g_set_rd
         assign set_view = latch_reg;
      end else begin : g_set_wo
         assign set_view = '0;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_LEVEL))    bus_rdata = level_reg;
      else if (bus_addr == ADDR_W'(OFS_SET)) bus_rdata = set_view;
      else if (bus_addr == ADDR_W'(OFS_DIR)) bus_rdata = dir_word;
   end

   // R5 (one write per cycle on the bus)
   wsel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wsel));
   // R10
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr >= ADDR_W'(NUM_REGS)) |-> (bus_rdata == '0));
   // R9
   clr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFS_CLR)) |-> (bus_rdata == '0));
   // R11
   pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;

   logic        wr0 = 0;
   logic [2:0]  ad0 = '0;
   logic [15:0] wd0 = '0, pi0 = '0;
   logic [15:0] rd0, po0, oe0;

   logic        wr1 = 0;
   logic [2:0]  ad1 = '0;
   logic [7:0]  wd1 = '0, pi1 = '0;
   logic [7:0]  rd1, po1, oe1;

   gpio_port_ctrl #(.WIDTH(16), .ADDR_W(3), .DIR_ONE_IS_OUT(1'b1),
                    .BIT_REVERSE(1'b1), .SET_READABLE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr0), .bus_addr(ad0),
      .bus_wdata(wd0), .bus_rdata(rd0), .pin_in(pi0),
      .pin_out(po0), .pin_oe(oe0));

   gpio_port_ctrl #(.WIDTH(8), .ADDR_W(3), .DIR_ONE_IS_OUT(1'b0),
                    .BIT_REVERSE(1'b0), .SET_READABLE(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr1), .bus_addr(ad1),
      .bus_wdata(wd1), .bus_rdata(rd1), .pin_in(pi1),
      .pin_out(po1), .pin_oe(oe1));

   function automatic logic [15:0] rev16(logic [15:0] v);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = v[15-i];
      return r;
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic write0(logic [2:0] a, logic [15:0] d);
      @(negedge clk); wr0 = 1; ad0 = a; wd0 = d;
      @(negedge clk); wr0 = 0;
   endtask

   task automatic read0(string req, logic [2:0] a, logic [15:0] exp);
      @(negedge clk); ad0 = a; #1;
      chk(req, 64'(rd0), 64'(exp));
   endtask

   task automatic write1(logic [2:0] a, logic [7:0] d);
      @(negedge clk); wr1 = 1; ad1 = a; wd1 = d;
      @(negedge clk); wr1 = 0;
   endtask

   task automatic read1(string req, logic [2:0] a, logic [7:0] exp);
      @(negedge clk); ad1 = a; #1;
      chk(req, 64'(rd1), 64'(exp));
   endtask

   task automatic t_reset;
      chk("R1 u0 pin_out", 64'(po0), 0);
      chk("R1 u0 pin_oe", 64'(oe0), 0);
      read0("R1 u0 dir", 3'd3, 16'h0000);
      chk("R1 u1 pin_oe", 64'(oe1), 0);
      read1("R1 u1 dir", 3'd3, 8'hFF);
   endtask

   task automatic t_latch_ops;
      write0(3'd0, 16'h0001);
      chk("R3 R8 load", 64'(po0), 64'(rev16(16'h0001)));
      read0("R9 set readback", 3'd1, 16'h0001);
      write0(3'd1, 16'h00F0);
      chk("R4 set", 64'(po0), 64'(rev16(16'h00F1)));
      write0(3'd2, 16'h0011);
      chk("R5 clear", 64'(po0), 64'(rev16(16'h00E0)));
      read0("R9 clr reads 0", 3'd2, 16'h0000);
      write1(3'd1, 8'h81);
      chk("R4 u1 set", 64'(po1), 64'h81);
      read1("R9 set unreadable", 3'd1, 8'h00);
      write1(3'd2, 8'h01);
      chk("R5 u1 clear", 64'(po1), 64'h80);
   endtask

   task automatic t_direction;
      write0(3'd3, 16'h00FF);
      chk("R6 R8 oe", 64'(oe0), 64'(rev16(16'h00FF)));
      read0("R6 dir read", 3'd3, 16'h00FF);
      write1(3'd3, 8'hF0);
      chk("R7 inverted oe", 64'(oe1), 64'h0F);
   endtask

   task automatic t_inputs;
      @(negedge clk); pi0 = 16'h0003; pi1 = 8'h5A; ad0 = 3'd0; ad1 = 3'd0;
      @(negedge clk); #1;
      chk("R2 one edge old", 64'(rd0), 0);
      @(negedge clk); #1;
      chk("R2 R8 two edges", 64'(rd0), 64'(rev16(16'h0003)));
      chk("R2 u1 level", 64'(rd1), 64'h5A);
   endtask

   task automatic t_idle_and_unmapped;
      @(negedge clk); ad0 = 3'd1; wd0 = 16'hFFFF; ad1 = 3'd3; wd1 = 8'h00;
      repeat (3) @(negedge clk);
      #1;
      chk("R11 latch hold", 64'(po0), 64'(rev16(16'h00E0)));
      chk("R11 dir hold", 64'(oe1), 64'h0F);
      read0("R10 offset 5", 3'd5, 16'h0000);
      read1("R10 offset 7", 3'd7, 8'h00);
      read0("R12 width 16 pins", 3'd0, rev16(16'h0003));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_latch_ops();
      t_direction();
      t_inputs();
      t_idle_and_unmapped();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule